// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counter behind a small word-wide register window. Software sets a reload value, an optional live count, a prescale ratio and two mode bits. While enabled, the counter steps down by one every (prescale + 1) clock cycles. When a step takes it from one to zero, a sticky expiry flag is set, and that flag drives a level interrupt. Depending on the reload mode, the counter then either refills from the reload value and keeps running, or stays at zero and stops.

The register port is synchronous. A write takes effect at the clock edge on which `req_i` and `we_i` are both high. Read data is combinational from `addr_i` whenever a read is presented. Only the low five address bits are decoded, so the window repeats every 32 bytes. Writing a one to the flag clears it. An expiry in the same cycle takes precedence over that clear.

Top module: `tick_timer`

## Requirements
- R1: After reset, the reload value, counter, control word and expiry flag all read zero, and `irq_o` is low.
- R2: Registers are selected by `addr_i[4:0]`: 0x00 reload value, 0x04 counter, 0x08 control, 0x0C expiry flag. Higher address bits are ignored. Any other low offset, including one that is not word aligned, reads zero and ignores writes.
- R3: Control bit 0 enables counting, bit 1 selects refill-on-expiry, and bits 15:8 hold the prescale value. All other control bits read back as zero.
- R4: An enabled, non-zero counter steps down once every (prescale + 1) cycles. The first step comes (prescale + 1) cycles after the enabling write or after a write to the counter or reload value.
- R5: Writing offset 0x00 sets both the reload value and the counter. Writing offset 0x04 sets only the counter.
- R6: A step from one sets the expiry flag. With refill selected, the counter takes the reload value and keeps counting. Without refill, it stays at zero and stops.
- R7: When the enable bit goes from 0 to 1 with the counter at zero and refill selected in the same write, the counter is first loaded from the reload value.
- R8: Reading offset 0x04 returns zero while the timer is disabled or the count is zero, and returns the live count otherwise.
- R9: Writing offset 0x0C with bit 0 set clears the expiry flag, and writing bit 0 as zero leaves it unchanged. The flag reads at bit 0, and `irq_o` equals the flag.
- R10: An expiry in the same cycle as a flag-clearing write leaves the flag set.
- R11: A zero counter never steps and never expires, including when it is enabled with a zero reload value.
- R12: Clearing the enable bit freezes the count, and setting it again resumes from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the count reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AddrW | Byte address; low five bits decoded |
| wdata_i | input | DataW | Write data |
| rdata_o | output | DataW | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt, equal to the expiry flag |

## Verification
A wrong prescale phase shows up as a counter read that changes one or more cycles early or late around a step boundary, so reads are timed to the cycle just before and just after a step. A wrong write-path priority in the counter shows up in the next counter read after enable or refill, or as an interrupt that arrives one period early or late. A flag mishandled on clear-versus-expiry collision is visible on `irq_o` in the following cycle. A count that failed to freeze on disable only becomes visible after re-enabling, so that case is read back immediately after the enable edge.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_DATA_W = 32;
  localparam int unsigned TT_PRE_W  = 8;
  localparam int unsigned TT_OFF_W  = 5;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned AUTO_BIT  = 1;
  localparam int unsigned PRE_LSB   = 8;

  typedef enum logic [TT_OFF_W-1:0] {
    OFF_LOAD = 5'h00,
    OFF_CNT  = 5'h04,
    OFF_CTRL = 5'h08,
    OFF_STAT = 5'h0C
  } tt_off_e;
endpackage

// File: rtl/tt_decode.sv
module tt_decode
  import tt_pkg::*;
#(
  parameter int unsigned AddrW = 8,
  parameter int unsigned DataW = TT_DATA_W,
  parameter int unsigned PreW  = TT_PRE_W
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [DataW-1:0] load_i,
  input  logic [DataW-1:0] count_i,
  input  logic             en_i,
  input  logic             auto_i,
  input  logic [PreW-1:0]  pre_i,
  input  logic             flag_i,
  output logic             wr_load_o,
  output logic             wr_cnt_o,
  output logic             wr_ctrl_o,
  output logic             wr_stat_o,
  output logic [DataW-1:0] rdata_o
);
  logic [TT_OFF_W-1:0] off;
  logic                wr;
  logic                unused_addr;

  assign off         = addr_i[TT_OFF_W-1:0];
  assign wr          = req_i && we_i;
  assign unused_addr = ^addr_i[AddrW-1:TT_OFF_W];

  assign wr_load_o = wr && (off == OFF_LOAD);
  assign wr_cnt_o  = wr && (off == OFF_CNT);
  assign wr_ctrl_o = wr && (off == OFF_CTRL);
  assign wr_stat_o = wr && (off == OFF_STAT);

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (off)
        OFF_LOAD: rdata_o = load_i;
        OFF_CNT:  rdata_o = (en_i && (count_i != '0)) ? count_i : '0;
        OFF_CTRL: begin
          rdata_o[EN_BIT]             = en_i;
          rdata_o[AUTO_BIT]           = auto_i;
          rdata_o[PRE_LSB +: PreW]    = pre_i;
        end
        OFF_STAT: rdata_o[0] = flag_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale
  import tt_pkg::*;
#(
  parameter int unsigned PreW = TT_PRE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic [PreW-1:0] pre_i,
  output logic            step_o
);
  logic [PreW-1:0] phase_q;

  // >= keeps a shrunk prescale from stalling a phase already past it
  assign step_o = run_i && !restart_i && (phase_q >= pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (run_i)     phase_q <= step_o ? '0 : phase_q + PreW'(1);
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int unsigned DataW = TT_DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic             fill_i,
  input  logic [DataW-1:0] load_i,
  input  logic             step_i,
  input  logic             auto_i,
  output logic [DataW-1:0] count_o,
  output logic             expire_o
);
  logic [DataW-1:0] count_q;

  assign count_o  = count_q;
  assign expire_o = step_i && (count_q == DataW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (wr_i)     count_q <= wdata_i;
    else if (fill_i)   count_q <= load_i;
    else if (expire_o) count_q <= auto_i ? load_i : '0;
    else if (step_i)   count_q <= count_q - DataW'(1);
  end
endmodule

// File: rtl/tt_status.sv
module tt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned AddrW = 8,
  parameter int unsigned DataW = TT_DATA_W,
  parameter int unsigned PreW  = TT_PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [DataW-1:0] wdata_i,
  output logic [DataW-1:0] rdata_o,
  output logic             irq_o
);
  logic             wr_load, wr_cnt, wr_ctrl, wr_stat;
  logic [DataW-1:0] load_q;
  logic             en_q, auto_q;
  logic [PreW-1:0]  pre_q;
  logic [DataW-1:0] count;
  logic             step, expire, flag;
  logic             en_rise, fill, restart, run;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[DataW-1:PRE_LSB+PreW], wdata_i[PRE_LSB-1:AUTO_BIT+1]};

  tt_decode #(.AddrW(AddrW), .DataW(DataW), .PreW(PreW)) i_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .load_i    (load_q),
    .count_i   (count),
    .en_i      (en_q),
    .auto_i    (auto_q),
    .pre_i     (pre_q),
    .flag_i    (flag),
    .wr_load_o (wr_load),
    .wr_cnt_o  (wr_cnt),
    .wr_ctrl_o (wr_ctrl),
    .wr_stat_o (wr_stat),
    .rdata_o   (rdata_o)
  );

  assign en_rise = wr_ctrl && !en_q && wdata_i[EN_BIT];
  assign fill    = en_rise && wdata_i[AUTO_BIT] && (count == '0);
  assign restart = wr_load || wr_cnt || en_rise;
  assign run     = en_q && (count != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_q <= '0;
    else if (wr_load) load_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      pre_q  <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[EN_BIT];
      auto_q <= wdata_i[AUTO_BIT];
      pre_q  <= wdata_i[PRE_LSB +: PreW];
    end
  end

  tt_prescale #(.PreW(PreW)) i_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (run),
    .pre_i     (pre_q),
    .step_o    (step)
  );

  tt_counter #(.DataW(DataW)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_load || wr_cnt),
    .wdata_i  (wdata_i),
    .fill_i   (fill),
    .load_i   (load_q),
    .step_i   (step),
    .auto_i   (auto_q),
    .count_o  (count),
    .expire_o (expire)
  );

  tt_status i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (wr_stat && wdata_i[0]),
    .flag_o (flag)
  );

  assign irq_o = flag;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tt_pkg::*;
#(
  parameter int unsigned AddrW = 8,
  parameter int unsigned DataW = TT_DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AddrW-1:0] addr_i,
  input logic [DataW-1:0] wdata_i,
  input logic [DataW-1:0] rdata_o,
  input logic             irq_o,
  input logic             en_q,
  input logic             auto_q,
  input logic [DataW-1:0] load_q,
  input logic [DataW-1:0] count,
  input logic             step,
  input logic             expire
);
  logic [TT_OFF_W-1:0] off;
  logic                wr_any;
  assign off    = addr_i[TT_OFF_W-1:0];
  assign wr_any = req_i && we_i &&
                  (off == OFF_LOAD || off == OFF_CNT || off == OFF_CTRL);

  p_irq_fall_needs_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i && off == OFF_STAT && wdata_i[0]));

  p_expire_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> irq_o);

  p_frozen_when_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_any) |=> $stable(count));

  p_step_decrements_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count > DataW'(1) && !wr_any) |=> (count == $past(count) - DataW'(1)));

  p_expire_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (count == ($past(auto_q) ? $past(load_q) : '0)));

  p_read_off_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off == OFF_CNT && !en_q) |-> (rdata_o == '0));

  p_zero_stays_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0 && !wr_any) |=> (count == '0 && !$past(expire)));
endmodule

bind tick_timer tick_timer_chk #(.AddrW(AddrW), .DataW(DataW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .auto_q  (auto_q),
  .load_q  (load_q),
  .count   (count),
  .step    (step),
  .expire  (expire)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] A_LOAD = 8'h00;
  localparam logic [AW-1:0] A_CNT  = 8'h04;
  localparam logic [AW-1:0] A_CTRL = 8'h08;
  localparam logic [AW-1:0] A_STAT = 8'h0C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [DW-1:0] data;
    int            irq;   // -1: don't care
    string         tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  tick_timer #(.AddrW(AW), .DataW(DW)) i_tick_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  // monitor: compares at the falling edge, half a cycle after the driver
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (rdata_o !== it.data) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata_o, it.data);
      end
      if (it.irq >= 0) begin
        n_cmp++;
        if (irq_o !== it.irq[0]) begin
          n_bad++;
          $display("FAIL %s: irq=%b expected=%0d", it.tag, irq_o, it.irq);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                    input int exp_irq, input string tag);
    sb_item_t it;
    it.data = exp_d; it.irq = exp_irq; it.tag = tag;
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    sb_q.push_back(it);
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_LOAD, 0, 0, "R1 load");
    rd(A_CNT,  0, 0, "R1 count");
    rd(A_CTRL, 0, 0, "R1 ctrl");
    rd(A_STAT, 0, 0, "R1 flag");

    // R2 decode: aliasing, unmapped and misaligned offsets
    wr(8'h20, 32'h11);
    rd(A_LOAD, 32'h11, -1, "R2 alias write");
    rd(8'hE0,  32'h11, -1, "R2 alias read");
    rd(8'h10,  0, -1, "R2 unmapped read");
    rd(8'h02,  0, -1, "R2 misaligned read");
    wr(8'h14, 32'hDEAD);
    wr(8'h01, 32'hBEEF);
    rd(A_LOAD, 32'h11, -1, "R2 unmapped write ignored load");
    rd(A_CTRL, 0, -1, "R2 unmapped write ignored ctrl");
    wr(A_CTRL, 32'h0000_FF01);
    rd(A_CNT, 32'h11, -1, "R2 unmapped write ignored count");
    wr(A_CTRL, 0);

    // R3 control layout
    wr(A_CTRL, 32'hFFFF_FFFC);
    rd(A_CTRL, 32'h0000_FF00, -1, "R3 ctrl readback");
    wr(A_CTRL, 0);

    // R5 load vs counter writes
    wr(A_LOAD, 32'h1234);
    wr(A_CTRL, 32'h0000_FF01);
    rd(A_CNT, 32'h1234, -1, "R5 load write sets count");
    wr(A_CNT, 32'h55);
    rd(A_CNT, 32'h55, -1, "R5 count write");
    rd(A_LOAD, 32'h1234, -1, "R5 count write keeps load");
    wr(A_CTRL, 0);

    // R4 prescale 3, count 5, one-shot
    wr(A_LOAD, 5);
    wr(A_CTRL, 32'h0000_0301);
    rd(A_CNT, 5, 0, "R4 at enable");
    idle(2);
    rd(A_CNT, 5, 0, "R4 before first step");
    rd(A_CNT, 4, 0, "R4 first step");
    idle(14);
    rd(A_STAT, 0, 0, "R6 flag before expiry");
    rd(A_STAT, 1, 1, "R6 flag at expiry");
    rd(A_CNT, 0, 1, "R6 one-shot stops at zero");
    idle(5);
    rd(A_CNT, 0, 1, "R6 one-shot stays at zero");
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, 1, 1, "R9 zero bit no effect");
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    rd(A_STAT, 0, 0, "R9 write one clears");

    // R6 refill, prescale 0, load 3
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CNT, 3, 0, "R6 refill start");
    rd(A_CNT, 2, 0, "R6 refill step");
    rd(A_CNT, 1, 0, "R6 refill step 2");
    rd(A_CNT, 3, 1, "R6 refilled after expiry");
    idle(1);
    wr(A_STAT, 1);
    rd(A_STAT, 1, 1, "R10 expiry beats clear");
    wr(A_STAT, 1);
    rd(A_STAT, 0, 0, "R9 clear between expiries");
    wr(A_CTRL, 0);
    wr(A_STAT, 1);

    // R8 and R12
    wr(A_CNT, 9);
    rd(A_CNT, 0, -1, "R8 disabled reads zero");
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CNT, 9, -1, "R8 enabled reads count");
    rd(A_CNT, 8, -1, "R12 counting");
    wr(A_CTRL, 0);
    idle(5);
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CNT, 6, -1, "R12 resumes from frozen value");
    wr(A_CTRL, 0);

    // R7 enable edge fill
    wr(A_LOAD, 7);
    wr(A_CNT, 0);
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CNT, 7, -1, "R7 fill on enable");
    wr(A_CTRL, 0);
    wr(A_STAT, 1);

    // R11 zero count never expires
    wr(A_LOAD, 0);
    wr(A_CTRL, 32'h0000_0003);
    idle(10);
    rd(A_STAT, 0, 0, "R11 zero reload no expiry");
    rd(A_CNT, 0, 0, "R11 zero reload count");
    wr(A_CTRL, 0);
    wr(A_LOAD, 5);
    wr(A_CNT, 0);
    wr(A_CTRL, 32'h0000_0001);
    idle(10);
    rd(A_STAT, 0, 0, "R11 zero count one-shot no expiry");
    wr(A_CTRL, 0);

    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule